// File: doc/BRIEF.md
# Receive Character Buffer with Per-Entry Error Flags

This block is the receive-side character store of a UART. The serial receiver
pushes each completed character into it together with three error indications:
a parity mismatch, a missing stop bit (framing), and a line-break detection.
The entries are kept side by side with the byte they describe. The host side
always sees the oldest character and its flags before it pops that entry, so
error reporting lines up with the character that caused it.

The block keeps a fill count and compares it with two programmable thresholds.
One threshold drives a level-sensitive interrupt request. The other drives a
DMA-ready line. That line either follows the threshold directly, or, in burst
mode, latches at the threshold and holds until the buffer drains. A character
that arrives with no free slot is dropped and a sticky overflow flag is set. A
synchronous clear empties everything.

Top module: `rx_err_fifo`

## Requirements
- R1: While `rst_ni` is low, `level_o` is 0 and `empty_o` is 1. `full_o`, `ovf_o`, `irq_o` and `dma_rdy_o` are all 0.
- R2: The buffer holds up to DEPTH (64) entries in first-in first-out order. `level_o` equals the number stored, `full_o` is 1 exactly at DEPTH and `empty_o` is 1 exactly at 0.
- R3: Each entry keeps the data byte and its parity (`wr_perr_i`), framing (`wr_ferr_i`) and break (`wr_brk_i`) flags. The oldest entry's byte and flags appear on `rd_data_o`, `rd_perr_o`, `rd_ferr_o` and `rd_brk_o` before `rd_en_i` removes it.
- R4: A write while full, with no read in the same cycle, is discarded. Stored entries and the level are unchanged, and `ovf_o` goes to 1 and stays there until a clear.
- R5: A write and a read in the same cycle while full are both accepted, the level stays at DEPTH and `ovf_o` is not set.
- R6: A read while empty has no effect. While empty, the data and flag outputs are all 0.
- R7: `irq_o` is 1 exactly while the level is at or above `irq_thr_i`, with a threshold of 0 treated as 1. It drops as soon as the level falls below the threshold.
- R8: With `dma_burst_i` = 0, `dma_rdy_o` is 1 exactly while the level is at or above `dma_thr_i`, with 0 treated as 1.
- R9: With `dma_burst_i` = 1, `dma_rdy_o` sets after an update that leaves the level at or above `dma_thr_i`. It then stays set until the buffer becomes empty.
- R10: `clr_i` empties the buffer and clears `ovf_o` and the burst latch on the next edge. It overrides a write or read in the same cycle.
- R11: Every write, read or clear is visible on all outputs right after the clock edge that samples it, one cycle with no further delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of contents and overflow |
| wr_valid_i | input | 1 | Receiver pushes a character |
| wr_data_i | input | DATA_W | Received character |
| wr_perr_i | input | 1 | Parity error of that character |
| wr_ferr_i | input | 1 | Framing error of that character |
| wr_brk_i | input | 1 | Break detected with that character |
| rd_en_i | input | 1 | Host pops the oldest entry |
| irq_thr_i | input | LVL_W | Interrupt threshold (0 acts as 1) |
| dma_thr_i | input | LVL_W | DMA threshold (0 acts as 1) |
| dma_burst_i | input | 1 | 1: latch DMA-ready until empty |
| rd_data_o | output | DATA_W | Oldest stored character |
| rd_perr_o | output | 1 | Parity flag of oldest entry |
| rd_ferr_o | output | 1 | Framing flag of oldest entry |
| rd_brk_o | output | 1 | Break flag of oldest entry |
| level_o | output | LVL_W | Number of stored entries |
| empty_o | output | 1 | No entries stored |
| full_o | output | 1 | DEPTH entries stored |
| ovf_o | output | 1 | Sticky overflow flag |
| irq_o | output | 1 | Interrupt request |
| dma_rdy_o | output | 1 | DMA request for received data |

## Verification
A pointer that slips shows up at the head outputs in the very next cycle as a
byte or flag combination that does not match the oldest queued entry. A count
that drifts shows up at once as a wrong `level_o`. It also moves the `full_o`,
`empty_o`, `irq_o` and `dma_rdy_o` edges away from the expected fill values. A
stale burst latch or overflow flag shows up in the cycle after the condition
that should have cleared or set it. Each output is therefore compared with a
reference queue every cycle rather than only at the end of a sequence.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef struct packed {
    logic brk;
    logic ferr;
    logic perr;
  } rx_err_t;

  localparam int ERR_W = $bits(rx_err_t);
endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl #(
  parameter int DEPTH = 64,
  parameter int PTR_W = $clog2(DEPTH),
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             wr_valid_i,
  input  logic             rd_en_i,
  output logic             we_o,
  output logic [PTR_W-1:0] wr_ptr_o,
  output logic [PTR_W-1:0] rd_ptr_o,
  output logic [LVL_W-1:0] level_o,
  output logic [LVL_W-1:0] level_nxt_o,
  output logic             ovf_o
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [LVL_W-1:0] level_q, level_d;
  logic             ovf_q;
  logic             rd_ok, wr_ok, ovf_evt;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    rd_ok   = rd_en_i && (level_q != '0);
    // a pop in the same cycle frees the slot the push needs
    wr_ok   = wr_valid_i && ((level_q != FULL_LVL) || rd_ok);
    ovf_evt = wr_valid_i && !wr_ok;
    level_d = level_q;
    if (clr_i) begin
      level_d = '0;
    end else if (wr_ok && !rd_ok) begin
      level_d = level_q + 1'b1;
    end else if (rd_ok && !wr_ok) begin
      level_d = level_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      ovf_q    <= 1'b0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      ovf_q    <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (rd_ok) rd_ptr_q <= ptr_inc(rd_ptr_q);
      level_q <= level_d;
      if (ovf_evt) ovf_q <= 1'b1;
    end
  end

  assign we_o        = wr_ok && !clr_i;
  assign wr_ptr_o    = wr_ptr_q;
  assign rd_ptr_o    = rd_ptr_q;
  assign level_o     = level_q;
  assign level_nxt_o = level_d;
  assign ovf_o       = ovf_q;
endmodule

// File: rtl/rxq_mem.sv
module rxq_mem #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 11,
  parameter int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [PTR_W-1:0] waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [PTR_W-1:0] raddr_i,
  output logic [WIDTH-1:0] rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/rxq_trig.sv
module rxq_trig #(
  parameter int LVL_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] level_nxt_i,
  input  logic [LVL_W-1:0] irq_thr_i,
  input  logic [LVL_W-1:0] dma_thr_i,
  input  logic             dma_burst_i,
  output logic             irq_o,
  output logic             dma_rdy_o
);
  logic [LVL_W-1:0] irq_eff, dma_eff;
  logic             hold_q;

  // zero threshold would assert on an empty buffer; treat as one
  assign irq_eff = (irq_thr_i == '0) ? LVL_W'(1) : irq_thr_i;
  assign dma_eff = (dma_thr_i == '0) ? LVL_W'(1) : dma_thr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
    end else if (clr_i || (level_nxt_i == '0)) begin
      hold_q <= 1'b0;
    end else if (level_nxt_i >= dma_eff) begin
      hold_q <= 1'b1;
    end
  end

  assign irq_o     = (level_i >= irq_eff);
  assign dma_rdy_o = dma_burst_i ? hold_q : (level_i >= dma_eff);
endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_valid_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_perr_i,
  input  logic              wr_ferr_i,
  input  logic              wr_brk_i,
  input  logic              rd_en_i,
  input  logic [LVL_W-1:0]  irq_thr_i,
  input  logic [LVL_W-1:0]  dma_thr_i,
  input  logic              dma_burst_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_perr_o,
  output logic              rd_ferr_o,
  output logic              rd_brk_o,
  output logic [LVL_W-1:0]  level_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              ovf_o,
  output logic              irq_o,
  output logic              dma_rdy_o
);
  import rxq_pkg::*;

  localparam int PTR_W = $clog2(DEPTH);
  localparam int ENT_W = DATA_W + ERR_W;

  logic             we;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] level, level_nxt;
  logic [ENT_W-1:0] wr_ent, rd_ent;
  rx_err_t          wr_err, rd_err;

  rxq_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LVL_W(LVL_W)) ctrl_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .wr_valid_i  (wr_valid_i),
    .rd_en_i     (rd_en_i),
    .we_o        (we),
    .wr_ptr_o    (wr_ptr),
    .rd_ptr_o    (rd_ptr),
    .level_o     (level),
    .level_nxt_o (level_nxt),
    .ovf_o       (ovf_o)
  );

  assign wr_err = '{brk: wr_brk_i, ferr: wr_ferr_i, perr: wr_perr_i};
  assign wr_ent = {wr_err, wr_data_i};

  rxq_mem #(.DEPTH(DEPTH), .WIDTH(ENT_W), .PTR_W(PTR_W)) mem_i (
    .clk_i   (clk_i),
    .we_i    (we),
    .waddr_i (wr_ptr),
    .wdata_i (wr_ent),
    .raddr_i (rd_ptr),
    .rdata_o (rd_ent)
  );

  rxq_trig #(.LVL_W(LVL_W)) trig_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr_i),
    .level_i     (level),
    .level_nxt_i (level_nxt),
    .irq_thr_i   (irq_thr_i),
    .dma_thr_i   (dma_thr_i),
    .dma_burst_i (dma_burst_i),
    .irq_o       (irq_o),
    .dma_rdy_o   (dma_rdy_o)
  );

  // head is masked to zero while empty so stale slots never leak out
  assign rd_err    = empty_o ? '0 : rx_err_t'(rd_ent[ENT_W-1:DATA_W]);
  assign rd_data_o = empty_o ? '0 : rd_ent[DATA_W-1:0];
  assign rd_perr_o = rd_err.perr;
  assign rd_ferr_o = rd_err.ferr;
  assign rd_brk_o  = rd_err.brk;

  assign level_o = level;
  assign empty_o = (level == '0);
  assign full_o  = (level == LVL_W'(DEPTH));
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 8,
  parameter int LVL_W  = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_i,
  input logic              wr_valid_i,
  input logic [DATA_W-1:0] wr_data_i,
  input logic              wr_perr_i,
  input logic              wr_ferr_i,
  input logic              wr_brk_i,
  input logic              rd_en_i,
  input logic [LVL_W-1:0]  irq_thr_i,
  input logic [LVL_W-1:0]  dma_thr_i,
  input logic              dma_burst_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              rd_perr_o,
  input logic              rd_ferr_o,
  input logic              rd_brk_o,
  input logic [LVL_W-1:0]  level_o,
  input logic              empty_o,
  input logic              full_o,
  input logic              ovf_o,
  input logic              irq_o,
  input logic              dma_rdy_o
);
  assert_level_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LVL_W'(DEPTH));

  assert_hold_when_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !wr_valid_i && !rd_en_i) |=> $stable(level_o));

  assert_pop_decrements_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && rd_en_i && !empty_o && !wr_valid_i) |=> (level_o == $past(level_o) - 1'b1));

  assert_drop_keeps_head_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && full_o && wr_valid_i && !rd_en_i) |=>
      (full_o && ovf_o && $stable(rd_data_o) && $stable({rd_brk_o, rd_ferr_o, rd_perr_o})));

  assert_ovf_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_o) |-> $past(full_o && wr_valid_i && !rd_en_i && !clr_i));

  assert_full_swap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && full_o && wr_valid_i && rd_en_i && !ovf_o) |=> (full_o && !ovf_o));

  assert_empty_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (rd_data_o == '0 && !rd_perr_o && !rd_ferr_o && !rd_brk_o && !irq_o));

  assert_burst_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dma_burst_i && dma_rdy_o && !clr_i && !rd_en_i) |=> (dma_rdy_o || !dma_burst_i));

  assert_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (empty_o && !ovf_o));
endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W), .LVL_W(LVL_W)) chk_i (.*);

// File: tb/rx_err_fifo_tb_top.sv
module rx_err_fifo_tb_top;
  localparam int DEPTH = 64;
  localparam int LVL_W = 7;

  logic clk_i = 1'b0;
  always #2 clk_i = ~clk_i;

  logic rst_ni, clr_i, wr_valid_i, wr_perr_i, wr_ferr_i, wr_brk_i, rd_en_i, dma_burst_i;
  logic [7:0] wr_data_i, rd_data_o;
  logic [LVL_W-1:0] irq_thr_i, dma_thr_i, level_o;
  logic rd_perr_o, rd_ferr_o, rd_brk_o, empty_o, full_o, ovf_o, irq_o, dma_rdy_o;

  rx_err_fifo dut_i (.*);

  logic [10:0] exp_q[$];
  bit m_ovf, m_hold, mon_en, done;
  int n_vec, n_err;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff(input int t);
    return (t == 0) ? 1 : t;
  endfunction

  // monitor: compares every output against the reference queue each cycle
  always @(negedge clk_i) begin
    if (mon_en) begin
      chk("R2 level", 32'(level_o), 32'(exp_q.size()));
      chk("R2 empty", 32'(empty_o), 32'(exp_q.size() == 0));
      chk("R2 full", 32'(full_o), 32'(exp_q.size() == DEPTH));
      if (exp_q.size() > 0)
        chk("R3 head entry", 32'({rd_brk_o, rd_ferr_o, rd_perr_o, rd_data_o}), 32'(exp_q[0]));
      else
        chk("R6 empty head", 32'({rd_brk_o, rd_ferr_o, rd_perr_o, rd_data_o}), 32'd0);
      chk("R4 ovf flag", 32'(ovf_o), 32'(m_ovf));
      chk("R7 irq", 32'(irq_o), 32'(exp_q.size() >= eff(int'(irq_thr_i))));
      if (dma_burst_i)
        chk("R9 dma burst", 32'(dma_rdy_o), 32'(m_hold));
      else
        chk("R8 dma level", 32'(dma_rdy_o), 32'(exp_q.size() >= eff(int'(dma_thr_i))));
    end
  end

  // driver: applies one cycle and advances the reference model at the edge
  task automatic step(input bit wr, input logic [7:0] d, input logic [2:0] e,
                      input bit rd, input bit clr);
    bit rd_ok, was_full;
    @(negedge clk_i);
    #1;
    wr_valid_i = wr; wr_data_i = d;
    {wr_brk_i, wr_ferr_i, wr_perr_i} = e;
    rd_en_i = rd; clr_i = clr;
    @(posedge clk_i);
    if (clr) begin
      exp_q.delete(); m_ovf = 0; m_hold = 0;
    end else begin
      rd_ok = rd && (exp_q.size() > 0);
      was_full = (exp_q.size() == DEPTH);
      if (rd_ok) void'(exp_q.pop_front());
      if (wr) begin
        if (!was_full || rd_ok) exp_q.push_back({e, d});
        else m_ovf = 1;
      end
      if (exp_q.size() == 0) m_hold = 0;
      else if (exp_q.size() >= eff(int'(dma_thr_i))) m_hold = 1;
    end
    #1;
    wr_valid_i = 0; rd_en_i = 0; clr_i = 0;
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [15:0] lfsr;
    rst_ni = 0; clr_i = 0; wr_valid_i = 0; wr_data_i = 0; wr_perr_i = 0;
    wr_ferr_i = 0; wr_brk_i = 0; rd_en_i = 0; dma_burst_i = 0;
    irq_thr_i = 7'd8; dma_thr_i = 7'd16;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 level", 32'(level_o), 0);
    chk("R1 empty", 32'(empty_o), 1);
    chk("R1 flags", 32'({full_o, ovf_o, irq_o, dma_rdy_o}), 0);
    rst_ni = 1;
    mon_en = 1;

    // fill to capacity with varied bytes and flag combinations
    for (int i = 0; i < DEPTH; i++) step(1, 8'(i * 37 + 5), 3'(i % 8), 0, 0);
    chk("R2 full at depth", 32'(full_o), 1);

    // overflow: three writes that must be dropped
    for (int i = 0; i < 3; i++) step(1, 8'hE0 + 8'(i), 3'b111, 0, 0);
    chk("R4 level unchanged", 32'(level_o), DEPTH);
    chk("R4 ovf set", 32'(ovf_o), 1);
    chk("R4 head preserved", 32'(rd_data_o), 32'(8'd5));

    // clear overflow, refill, then swap at full
    step(0, 0, 0, 0, 1);
    chk("R10 cleared", 32'({ovf_o, empty_o}), 32'b01);
    for (int i = 0; i < DEPTH; i++) step(1, 8'(i ^ 8'h5A), 3'(i % 5), 0, 0);
    step(1, 8'hA5, 3'b010, 1, 0);
    chk("R5 still full", 32'(full_o), 1);
    chk("R5 no overflow", 32'(ovf_o), 0);

    // drain fully, then read while empty
    for (int i = 0; i < DEPTH + 2; i++) step(0, 0, 0, 1, 0);
    chk("R6 empty after drain", 32'(level_o), 0);

    // clear wins over a same-cycle write
    for (int i = 0; i < 5; i++) step(1, 8'(i + 1), 3'b001, 0, 0);
    step(1, 8'h77, 3'b100, 1, 1);
    chk("R10 clear overrides write", 32'(level_o), 0);

    // interrupt threshold, including zero
    irq_thr_i = 0;
    step(1, 8'h11, 3'b000, 0, 0);
    chk("R7 zero threshold acts as one", 32'(irq_o), 1);
    chk("R11 level one cycle after write", 32'(level_o), 1);
    irq_thr_i = 7'd4;
    for (int i = 0; i < 4; i++) step(1, 8'(i + 8'h20), 3'(i), 0, 0);
    chk("R7 irq at threshold", 32'(irq_o), 1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 1, 0);
    chk("R7 irq drops below", 32'(irq_o), 0);
    step(0, 0, 0, 0, 1);

    // burst DMA mode
    dma_burst_i = 1; dma_thr_i = 7'd4;
    for (int i = 0; i < 6; i++) step(1, 8'(i + 8'h40), 3'b000, 0, 0);
    for (int i = 0; i < 5; i++) step(0, 0, 0, 1, 0);
    chk("R9 held below threshold", 32'(dma_rdy_o), 1);
    step(0, 0, 0, 1, 0);
    chk("R9 released on empty", 32'(dma_rdy_o), 0);

    // mixed traffic in both DMA modes
    lfsr = 16'hACE1;
    for (int i = 0; i < 1200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i == 600) begin dma_burst_i = 0; dma_thr_i = 7'd0; irq_thr_i = 7'd60; end
      step(lfsr[0] | lfsr[1], lfsr[9:2], lfsr[12:10],
           (i % 200 < 100) ? (lfsr[3] & lfsr[4]) : (lfsr[3] | lfsr[4]),
           (lfsr[15:5] == 11'h3FF));
    end

    done = 1;
    summary();
  end
endmodule